// File: doc/BRIEF.md
# SPI-Mode Memory Card Command Issuer

This block drives a memory card wired in SPI mode. On a start strobe it takes a 6-bit command index and a 32-bit argument and sends a seven-byte command frame. The frame's CRC7 is built byte by byte as the frame goes out. It then clocks out all-ones bytes to poll for the card's one-byte R1 status. It reports the status byte, a no-card flag, a coarse error class and a single-cycle done pulse.

A separate power-up strobe holds chip-select high and sends a run of all-ones bytes at the slow rate, which gives the card the clocks it needs before its first command. Each command uses either the slow or the fast SCLK rate, picked by one select input that is captured with the start strobe. The bus runs in SPI mode 0: SCLK idles low, MOSI changes after a falling edge, and MISO is sampled on the rising edge.

Top module: `card_cmd_issuer`

## Requirements
- R1: After reset, cs_no is 1, sclk_o is 0, busy_o and done_o are 0, r1_o is 0x00 and err_class_o is 0. Whenever busy_o is 0, cs_no is 1 and sclk_o is 0.
- R2: A pulse on init_i while idle sends INIT_BYTES bytes of 0xFF (8*INIT_BYTES SCLK rising edges, default 144) with cs_no held at 1, always at the slow rate.
- R3: A pulse on start_i while idle sends seven bytes MSB first with cs_no low: 0xFF, then 0x40 | cmd_idx_i, then cmd_arg_i from bits 31:24 down to bits 7:0, then the CRC byte.
- R4: The CRC byte is {crc7, 1}. crc7 is computed over frame bytes 1 to 5 with polynomial x^7+x^3+1, starting from zero and taking bits MSB first (index 0, argument 0 gives 0x95; index 8, argument 0x1AA gives 0x87).
- R5: After the frame, the block polls with 0xFF bytes. The first polled byte is never taken as R1. The first later byte with bit 7 clear is reported on r1_o.
- R6: If none of POLL_MAX (default 8) polled bytes is taken, r1_o is 0xFF and no_resp_o is 1, and exactly POLL_MAX poll bytes are sent.
- R7: err_class_o is set with done_o, by priority: 1 when r1_o is 0xFF, 2 when bit 3 of r1_o is set, 3 when any of bits 6:1 is set, and 0 otherwise.
- R8: done_o is high for one cycle while cs_no is still low. One more 0xFF byte (8 SCLK rising edges) follows with cs_no low, and then cs_no rises.
- R9: With fast_i at 1 when start_i is pulsed, SCLK is high for FAST_HALF clock cycles per bit (default 1). With fast_i at 0, and always during init, it is high for SLOW_HALF cycles (default 4).
- R10: start_i and init_i have no effect while busy_o is 1. The frame in progress is unchanged and no init sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Starts the power-up dummy-byte run |
| start_i | input | 1 | Starts one command |
| fast_i | input | 1 | Selects the fast SCLK rate for the command |
| cmd_idx_i | input | 6 | Command index |
| cmd_arg_i | input | 32 | Command argument |
| miso_i | input | 1 | Serial data from the card |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the card |
| cs_no | output | 1 | Card chip-select, active low |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | Single-cycle pulse when the result is valid |
| r1_o | output | 8 | Status byte, or 0xFF when no card answered |
| no_resp_o | output | 1 | No valid status byte arrived |
| err_class_o | output | 2 | 0 none, 1 no card, 2 CRC error, 3 other error |

## Verification
The assertions assume that the card changes MISO only after a falling SCLK edge, that strobes come from the clock domain, and that fast_i only matters when start_i is pulsed. The bench models the card at the SCLK edges: it captures MOSI on the rising edge, moves to the next MISO bit on the falling edge, and loads each reply byte from a per-test table indexed by byte position since chip-select fell. Strobes are driven one cycle wide between clock edges, and the busy-time strobes in the R10 scenario are the only ones sent outside the idle state.

// File: rtl/cmd_issuer_pkg.sv
package cmd_issuer_pkg;
  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_NOCARD = 2'd1,
    ERR_CRC    = 2'd2,
    ERR_OTHER  = 2'd3
  } err_class_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_INIT, ST_FRAME, ST_POLL, ST_TAIL
  } seq_state_e;

  localparam logic [7:0] FILL_BYTE  = 8'hFF;
  localparam logic [7:0] CMD_PREFIX = 8'h40;
  localparam logic [6:0] CRC_POLY   = 7'h09;
  localparam int unsigned FRAME_LEN = 7;

  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic [7:0] d);
    logic [6:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[6] ^ d[i];
      r  = {r[5:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  function automatic err_class_e classify(input logic [7:0] v);
    if (v == FILL_BYTE)        return ERR_NOCARD;
    else if (v[3])             return ERR_CRC;
    else if (|(v & 8'h7E))     return ERR_OTHER;
    else                       return ERR_NONE;
  endfunction
endpackage

// File: rtl/cmd_spi_byte_eng.sv
module cmd_spi_byte_eng #(
  parameter int unsigned SLOW_HALF = 4,
  parameter int unsigned FAST_HALF = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fast_i,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  localparam int unsigned HALF_MAX = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
  localparam int unsigned CW = $clog2(HALF_MAX + 1);

  logic          active_q;
  logic [CW-1:0] hcnt_q;
  logic [CW-1:0] half;
  logic [2:0]    bitc_q;
  logic [7:0]    tx_q, rx_q;
  logic          sclk_q, done_q;

  assign half = fast_i ? CW'(FAST_HALF) : CW'(SLOW_HALF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      hcnt_q   <= '0;
      bitc_q   <= '0;
      tx_q     <= 8'hFF;
      rx_q     <= '0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (start_i) begin
          active_q <= 1'b1;
          tx_q     <= tx_i;
          hcnt_q   <= '0;
          bitc_q   <= '0;
        end
      end else if (hcnt_q == half - CW'(1)) begin
        hcnt_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[6:0], miso_i};
        end else begin
          sclk_q <= 1'b0;
          tx_q   <= {tx_q[6:0], 1'b1};
          bitc_q <= bitc_q + 3'd1;
          if (bitc_q == 3'd7) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end
        end
      end else begin
        hcnt_q <= hcnt_q + CW'(1);
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = tx_q[7];
  assign done_o = done_q;
  assign rx_o   = rx_q;
endmodule

// File: rtl/cmd_crc7_acc.sv
module cmd_crc7_acc
  import cmd_issuer_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       en_i,
  input  logic [7:0] data_i,
  output logic [6:0] crc_o
);
  logic [6:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (clear_i) crc_q <= '0;
    else if (en_i)    crc_q <= crc7_step(crc_q, data_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/cmd_seq_ctrl.sv
module cmd_seq_ctrl
  import cmd_issuer_pkg::*;
#(
  parameter int unsigned INIT_BYTES = 18,
  parameter int unsigned POLL_MAX   = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        start_i,
  input  logic        fast_i,
  input  logic [5:0]  cmd_idx_i,
  input  logic [31:0] cmd_arg_i,
  input  logic        byte_done_i,
  input  logic [7:0]  rx_i,
  input  logic [6:0]  crc_i,
  output logic        byte_start_o,
  output logic [7:0]  byte_tx_o,
  output logic        rate_fast_o,
  output logic        crc_clr_o,
  output logic        crc_en_o,
  output logic [7:0]  crc_data_o,
  output logic        cs_no,
  output logic        busy_o,
  output logic        done_o,
  output logic [7:0]  r1_o,
  output logic        no_resp_o,
  output logic [1:0]  err_class_o
);
  localparam int unsigned M1 = (INIT_BYTES > POLL_MAX) ? INIT_BYTES : POLL_MAX;
  localparam int unsigned M2 = (M1 > FRAME_LEN) ? M1 : FRAME_LEN;
  localparam int unsigned CNT_W = $clog2(M2 + 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [5:0]       idx_q;
  logic [31:0]      arg_q;
  logic [2:0]       nxt_k;
  logic [7:0]       frame_nxt;
  logic             poll_hit;
  logic [7:0]       res_v;

  always_comb begin
    nxt_k = cnt_q[2:0] + 3'd1;
    unique case (nxt_k)
      3'd1:    frame_nxt = CMD_PREFIX | {2'b00, idx_q};
      3'd2:    frame_nxt = arg_q[31:24];
      3'd3:    frame_nxt = arg_q[23:16];
      3'd4:    frame_nxt = arg_q[15:8];
      3'd5:    frame_nxt = arg_q[7:0];
      3'd6:    frame_nxt = {crc_i, 1'b1};
      default: frame_nxt = FILL_BYTE;
    endcase
    poll_hit = (cnt_q != '0) && !rx_i[7];
    res_v    = poll_hit ? rx_i : FILL_BYTE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      idx_q        <= '0;
      arg_q        <= '0;
      byte_start_o <= 1'b0;
      byte_tx_o    <= FILL_BYTE;
      rate_fast_o  <= 1'b0;
      crc_clr_o    <= 1'b0;
      crc_en_o     <= 1'b0;
      crc_data_o   <= '0;
      cs_no        <= 1'b1;
      done_o       <= 1'b0;
      r1_o         <= '0;
      no_resp_o    <= 1'b0;
      err_class_o  <= ERR_NONE;
    end else begin
      byte_start_o <= 1'b0;
      crc_clr_o    <= 1'b0;
      crc_en_o     <= 1'b0;
      done_o       <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (init_i) begin
            state_q      <= ST_INIT;
            cnt_q        <= '0;
            rate_fast_o  <= 1'b0;
            byte_start_o <= 1'b1;
            byte_tx_o    <= FILL_BYTE;
          end else if (start_i) begin
            state_q      <= ST_FRAME;
            cnt_q        <= '0;
            idx_q        <= cmd_idx_i;
            arg_q        <= cmd_arg_i;
            rate_fast_o  <= fast_i;
            crc_clr_o    <= 1'b1;
            cs_no        <= 1'b0;
            byte_start_o <= 1'b1;
            byte_tx_o    <= FILL_BYTE;
          end
        end
        ST_INIT: if (byte_done_i) begin
          if (cnt_q == CNT_W'(INIT_BYTES - 1)) begin
            state_q <= ST_IDLE;
          end else begin
            cnt_q        <= cnt_q + CNT_W'(1);
            byte_start_o <= 1'b1;
            byte_tx_o    <= FILL_BYTE;
          end
        end
        ST_FRAME: if (byte_done_i) begin
          byte_start_o <= 1'b1;
          if (cnt_q == CNT_W'(FRAME_LEN - 1)) begin
            state_q   <= ST_POLL;
            cnt_q     <= '0;
            byte_tx_o <= FILL_BYTE;
          end else begin
            cnt_q     <= cnt_q + CNT_W'(1);
            byte_tx_o <= frame_nxt;
            if (nxt_k <= 3'd5) begin
              crc_en_o   <= 1'b1;
              crc_data_o <= frame_nxt;
            end
          end
        end
        ST_POLL: if (byte_done_i) begin
          byte_start_o <= 1'b1;
          byte_tx_o    <= FILL_BYTE;
          if (poll_hit || cnt_q == CNT_W'(POLL_MAX - 1)) begin
            state_q     <= ST_TAIL;
            r1_o        <= res_v;
            no_resp_o   <= !poll_hit;
            err_class_o <= classify(res_v);
            done_o      <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_TAIL: if (byte_done_i) begin
          state_q <= ST_IDLE;
          cs_no   <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/card_cmd_issuer.sv
module card_cmd_issuer #(
  parameter int unsigned SLOW_HALF  = 4,
  parameter int unsigned FAST_HALF  = 1,
  parameter int unsigned INIT_BYTES = 18,
  parameter int unsigned POLL_MAX   = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        start_i,
  input  logic        fast_i,
  input  logic [5:0]  cmd_idx_i,
  input  logic [31:0] cmd_arg_i,
  input  logic        miso_i,
  output logic        sclk_o,
  output logic        mosi_o,
  output logic        cs_no,
  output logic        busy_o,
  output logic        done_o,
  output logic [7:0]  r1_o,
  output logic        no_resp_o,
  output logic [1:0]  err_class_o
);
  logic       byte_start, byte_done, rate_fast;
  logic [7:0] byte_tx, byte_rx;
  logic       crc_clr, crc_en;
  logic [7:0] crc_data;
  logic [6:0] crc_val;

  cmd_seq_ctrl #(
    .INIT_BYTES(INIT_BYTES),
    .POLL_MAX  (POLL_MAX)
  ) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_i      (init_i),
    .start_i     (start_i),
    .fast_i      (fast_i),
    .cmd_idx_i   (cmd_idx_i),
    .cmd_arg_i   (cmd_arg_i),
    .byte_done_i (byte_done),
    .rx_i        (byte_rx),
    .crc_i       (crc_val),
    .byte_start_o(byte_start),
    .byte_tx_o   (byte_tx),
    .rate_fast_o (rate_fast),
    .crc_clr_o   (crc_clr),
    .crc_en_o    (crc_en),
    .crc_data_o  (crc_data),
    .cs_no       (cs_no),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .r1_o        (r1_o),
    .no_resp_o   (no_resp_o),
    .err_class_o (err_class_o)
  );

  cmd_crc7_acc i_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(crc_clr),
    .en_i   (crc_en),
    .data_i (crc_data),
    .crc_o  (crc_val)
  );

  cmd_spi_byte_eng #(
    .SLOW_HALF(SLOW_HALF),
    .FAST_HALF(FAST_HALF)
  ) i_eng (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fast_i (rate_fast),
    .start_i(byte_start),
    .tx_i   (byte_tx),
    .miso_i (miso_i),
    .sclk_o (sclk_o),
    .mosi_o (mosi_o),
    .done_o (byte_done),
    .rx_o   (byte_rx)
  );
endmodule

// File: rtl/card_cmd_issuer_chk.sv
module card_cmd_issuer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sclk_o,
  input logic       mosi_o,
  input logic       cs_no,
  input logic       busy_o,
  input logic       done_o,
  input logic [7:0] r1_o,
  input logic       no_resp_o,
  input logic [1:0] err_class_o
);
  // R1
  idle_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs_no && !sclk_o));

  // R2
  init_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cs_no && $rose(sclk_o)) |-> mosi_o);

  // R5
  r1_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !no_resp_o) |-> !r1_o[7]);

  // R6
  noresp_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (no_resp_o == (r1_o == 8'hFF)));

  // R7
  nocard_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((err_class_o == 2'd1) == no_resp_o));

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  done_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!cs_no && busy_o));
endmodule

bind card_cmd_issuer card_cmd_issuer_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sclk_o     (sclk_o),
  .mosi_o     (mosi_o),
  .cs_no      (cs_no),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .r1_o       (r1_o),
  .no_resp_o  (no_resp_o),
  .err_class_o(err_class_o)
);

// File: tb/test_card_cmd_issuer.sv
`timescale 1ns/1ps
module test_card_cmd_issuer;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic init_i = 1'b0, start_i = 1'b0, fast_i = 1'b0;
  logic [5:0] cmd_idx_i = '0;
  logic [31:0] cmd_arg_i = '0;
  logic miso_i;
  logic sclk_o, mosi_o, cs_no, busy_o, done_o, no_resp_o;
  logic [7:0] r1_o;
  logic [1:0] err_class_o;

  int tests = 0, fails = 0;

  always #4 clk_i = ~clk_i;

  card_cmd_issuer i_card_cmd_issuer (.*);

  // card model
  logic [7:0] out_sh = 8'hFF, in_sh = 8'h00;
  int bitc = 0, bytec = 0;
  logic [7:0] got [0:31];
  logic [7:0] poll_resp [0:15];
  int hi_rises = 0, hi_zeros = 0;

  assign miso_i = cs_no ? 1'b1 : out_sh[7];

  always @(negedge cs_no) begin bytec = 0; bitc = 0; out_sh = 8'hFF; end
  always @(posedge sclk_o) begin
    if (!cs_no) begin
      in_sh = {in_sh[6:0], mosi_o};
      bitc++;
      if (bitc == 8) begin
        if (bytec < 32) got[bytec] = in_sh;
        bytec++;
        bitc = 0;
      end
    end else begin
      hi_rises++;
      if (!mosi_o) hi_zeros++;
    end
  end
  always @(negedge sclk_o) if (!cs_no) begin
    if (bitc == 0) out_sh = (bytec >= 7 && bytec < 23) ? poll_resp[bytec-7] : 8'hFF;
    else out_sh = {out_sh[6:0], 1'b1};
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_crc(input logic [7:0] b [0:4]);
    logic [7:0] c8 = 8'h00;
    for (int n = 0; n < 5; n++)
      for (int j = 7; j >= 0; j--) begin
        c8 = (c8[7] ^ b[n][j]) ? ((c8 << 1) ^ 8'h12) : (c8 << 1);
      end
    return c8[7:1];
  endfunction

  logic [7:0] c_r1; logic c_nr; logic [1:0] c_err;
  int hi_w, tail_rises;
  bit done_twice;

  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input bit fast,
                         input bit poke);
    int guard = 0;
    bit prev;
    @(negedge clk_i);
    cmd_idx_i = idx; cmd_arg_i = arg; fast_i = fast; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (!sclk_o) @(negedge clk_i);
    hi_w = 0;
    while (sclk_o) begin hi_w++; @(negedge clk_i); end
    if (poke) begin
      cmd_idx_i = 6'd5; start_i = 1'b1; init_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0; init_i = 1'b0;
    end
    while (!done_o && guard < 20000) begin guard++; @(negedge clk_i); end
    c_r1 = r1_o; c_nr = no_resp_o; c_err = err_class_o;
    chk(cs_no == 1'b0, "R8 cs low at done", cs_no, 0);
    @(negedge clk_i);
    done_twice = done_o;
    tail_rises = 0; prev = sclk_o; guard = 0;
    while (!cs_no && guard < 20000) begin
      guard++;
      @(negedge clk_i);
      if (sclk_o && !prev) tail_rises++;
      prev = sclk_o;
    end
    chk(!done_twice, "R8 done one cycle", done_twice, 0);
    chk(tail_rises == 8, "R8 tail byte", tail_rises, 8);
  endtask

  task automatic check_frame(input logic [5:0] idx, input logic [31:0] arg, input string tag);
    logic [7:0] b [0:4];
    b[0] = 8'h40 | {2'b00, idx};
    b[1] = arg[31:24]; b[2] = arg[23:16]; b[3] = arg[15:8]; b[4] = arg[7:0];
    chk(got[0] == 8'hFF, {tag, " R3 filler"}, got[0], 8'hFF);
    for (int n = 0; n < 5; n++) chk(got[n+1] == b[n], {tag, " R3 frame byte"}, got[n+1], b[n]);
    chk(got[6] == {ref_crc(b), 1'b1}, {tag, " R4 crc byte"}, got[6], {ref_crc(b), 1'b1});
  endtask

  task automatic fill_resp(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    for (int n = 0; n < 16; n++) poll_resp[n] = 8'hFF;
    poll_resp[0] = a; poll_resp[1] = b; poll_resp[2] = c;
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk(cs_no == 1'b1 && sclk_o == 1'b0, "R1 reset lines", {cs_no, sclk_o}, 2'b10);
    chk(!busy_o && !done_o, "R1 reset flags", {busy_o, done_o}, 0);
    chk(r1_o == 8'h00 && err_class_o == 2'd0, "R1 reset result", r1_o, 0);
  endtask

  task automatic t_init;
    int guard = 0, w = 0;
    @(negedge clk_i); init_i = 1'b1;
    @(negedge clk_i); init_i = 1'b0;
    while (!sclk_o) @(negedge clk_i);
    while (sclk_o) begin w++; @(negedge clk_i); end
    while (busy_o && guard < 20000) begin guard++; chk(cs_no, "R2 cs high in init", cs_no, 1); @(negedge clk_i); end
    chk(hi_rises == 144, "R2 init clocks", hi_rises, 144);
    chk(hi_zeros == 0, "R2 init all ones", hi_zeros, 0);
    chk(w == 4, "R9 init slow rate", w, 4);
  endtask

  task automatic t_cmd0;
    fill_resp(8'h01, 8'hFF, 8'h01);
    run_cmd(6'd0, 32'h0, 1'b0, 1'b0);
    check_frame(6'd0, 32'h0, "cmd0");
    chk(got[6] == 8'h95, "R4 known crc cmd0", got[6], 8'h95);
    chk(c_r1 == 8'h01 && !c_nr, "R5 first poll skipped", c_r1, 8'h01);
    chk(c_err == 2'd0, "R7 idle is none", c_err, 0);
    chk(bytec == 11, "R5 poll stops on hit", bytec, 11);
    chk(hi_w == 4, "R9 slow rate", hi_w, 4);
  endtask

  task automatic t_cmd8;
    fill_resp(8'h00, 8'h05, 8'h01);
    run_cmd(6'd8, 32'h0000_01AA, 1'b1, 1'b0);
    check_frame(6'd8, 32'h0000_01AA, "cmd8");
    chk(got[6] == 8'h87, "R4 known crc cmd8", got[6], 8'h87);
    chk(c_r1 == 8'h05, "R5 second poll taken", c_r1, 8'h05);
    chk(c_err == 2'd3, "R7 other error", c_err, 3);
    chk(hi_w == 1, "R9 fast rate", hi_w, 1);
  endtask

  task automatic t_crc_err;
    fill_resp(8'hFF, 8'hFF, 8'h0D);
    run_cmd(6'd55, 32'hA5C3_0F81, 1'b1, 1'b0);
    check_frame(6'd55, 32'hA5C3_0F81, "crcerr");
    chk(c_r1 == 8'h0D, "R5 third poll taken", c_r1, 8'h0D);
    chk(c_err == 2'd2, "R7 crc class wins", c_err, 2);
  endtask

  task automatic t_nocard;
    fill_resp(8'hFF, 8'hFF, 8'hFF);
    poll_resp[8] = 8'h00;
    run_cmd(6'd63, 32'hFFFF_FFFF, 1'b1, 1'b0);
    check_frame(6'd63, 32'hFFFF_FFFF, "nocard");
    chk(c_r1 == 8'hFF && c_nr, "R6 no card result", {c_nr, c_r1}, 9'h1FF);
    chk(bytec == 16, "R6 poll limit", bytec, 16);
    chk(c_err == 2'd1, "R7 no card class", c_err, 1);
  endtask

  task automatic t_busy_ignore;
    int r0;
    r0 = hi_rises;
    fill_resp(8'hFF, 8'h00, 8'hFF);
    run_cmd(6'd17, 32'h1234_5678, 1'b1, 1'b1);
    check_frame(6'd17, 32'h1234_5678, "busy");
    chk(c_r1 == 8'h00 && c_err == 2'd0, "R10 result intact", c_r1, 0);
    repeat (20) @(negedge clk_i);
    chk(!busy_o && hi_rises == r0, "R10 no init run", hi_rises - r0, 0);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int n = 0; n < 32; n++) got[n] = 8'h00;
    for (int n = 0; n < 16; n++) poll_resp[n] = 8'hFF;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_reset();
    t_init();
    t_cmd0();
    t_cmd8();
    t_crc_err();
    t_nocard();
    t_busy_ignore();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule